// File: doc/BRIEF.md
# Fixed-Width Truncated Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns an N-bit result that approximates the upper half of the 2N-bit product. It never forms the full partial-product matrix. It generates only the N result columns and a small band of guard columns beneath them, and it leaves out every column below that band entirely. A fixed bias constant goes into the kept columns to make up for the discarded weight. The remaining bits are compressed column by column into two rows. A narrow adder then sums the two rows, and the guard bits drop away. The result is faithfully rounded: it is always one of the two integers that bracket the exact product divided by 2^N.

The datapath is purely combinational and holds no state. The operands enter on a valid/ready stream and the result leaves on a second stream in the same cycle. The handshake only passes through the block:

- `res_valid` follows `in_valid`.
- `in_ready` follows `res_ready`.
- A transfer occurs in any cycle where both valid and ready are high.

Under back-pressure (`res_ready` low), the source must hold its operands and `in_valid` steady until it sees `in_ready`. The block has no storage that could hold them. Typical use is inside a filter or transform datapath where only N product bits are kept.

Top module: `trunc_mul`

## Requirements
- R1: Both operands are unsigned and N bits wide (8 by default). The result is N bits wide and approximates the exact product divided by 2^N.
- R2: For every operand pair, `prod` equals floor(a*b / 2^N) or floor(a*b / 2^N) + 1, so the absolute error is below one unit in the last place.
- R3: The result never wraps. The internal final sum never carries out of its top column, and `prod` is never below floor(a*b / 2^N).
- R4: When either operand is zero, `prod` is 0.
- R5: When the low N bits of the exact product are all zero, `prod` equals the exact upper half with no rounding step.
- R6: When both operands are all ones, `prod` is 2^N - 2 (254 at N = 8).
- R7: In the same cycle, `res_valid` equals `in_valid` and `in_ready` equals `res_ready`. `prod` depends only on the operands and is unchanged by either handshake input.
- R8: When a*b is below 2^(N-GUARD) (32 with the defaults of N = 8 and GUARD = 3), `prod` is 0, because every set partial-product bit lies in a deleted column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is valid |
| in_ready | output | 1 | Block can take the operand pair (mirrors `res_ready`) |
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| res_valid | output | 1 | `prod` is valid (mirrors `in_valid`) |
| res_ready | input | 1 | Downstream can take the result |
| prod | output | N | Faithfully rounded upper N bits of op_a*op_b |

## Verification
The assertions are immediate checks on a combinational datapath. They assume the two operands are known two-state values that change together, so the checker never sees one operand updated and the other stale. They also assume the handshake inputs are always driven. The stimulus loads both operands in a single assignment shortly after a rising edge and reads the result only at the falling edge, once the logic has settled. It steps through every one of the 65,536 operand pairs with the handshake held open, and it holds the operands fixed while toggling the ready and valid inputs.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

  // Target column height for Dadda stage k (k = 1 gives 2).
  function automatic int dadda_height(input int k);
    int d;
    d = 2;
    for (int i = 1; i < k; i++) d = (d * 3) / 2;
    return d;
  endfunction

  // Number of reduction stages needed to bring maxh bits down to two.
  function automatic int dadda_stages(input int maxh);
    int s;
    s = 0;
    for (int i = 1; i < 32; i++)
      if (dadda_height(i) < maxh) s = i;
    return s;
  endfunction

  // Largest value the deleted columns 0..m-1 could have held.
  function automatic int deleted_max(input int m);
    int t;
    t = 0;
    for (int j = 0; j < m; j++) t += (j + 1) << j;
    return t;
  endfunction

  // Bias: deleted maximum rounded up to a multiple of the lowest kept weight.
  function automatic int corr_const(input int n, input int g);
    int m;
    m = n - g;
    return ((deleted_max(m) + (1 << m) - 1) >> m) << m;
  endfunction

  // Bits in absolute column c of an n x n matrix, plus one bias bit if set.
  function automatic int col_height(input int c, input int n, input int corr);
    int lo, hi, npp;
    lo  = (c > n - 1) ? c - n + 1 : 0;
    hi  = (c < n - 1) ? c : n - 1;
    npp = (hi >= lo) ? hi - lo + 1 : 0;
    return npp + ((corr >> c) & 1);
  endfunction

endpackage

// File: rtl/tmul_ppgen.sv
module tmul_ppgen
  import tmul_pkg::*;
#(
  parameter int N    = 8,
  parameter int M    = 5,
  parameter int NK   = 11,
  parameter int MAXH = 9,
  parameter int CORR = 160
) (
  input  logic [N-1:0]                op_a,
  input  logic [N-1:0]                op_b,
  output logic [NK-1:0][MAXH-1:0]     mat
);

  // Only absolute columns M .. 2N-1 are built; the rest never exist.
  for (genvar k = 0; k < NK; k++) begin : g_col
    localparam int C   = M + k;
    localparam int LO  = (C > N - 1) ? C - N + 1 : 0;
    localparam int HI  = (C < N - 1) ? C : N - 1;
    localparam int NPP = (HI >= LO) ? HI - LO + 1 : 0;
    localparam bit HAS_BIAS = ((CORR >> C) & 1) == 1;
    for (genvar s = 0; s < MAXH; s++) begin : g_slot
      if (s < NPP) begin : g_pp
        assign mat[k][s] = op_a[LO+s] & op_b[C-LO-s];
      end else if (s == NPP && HAS_BIAS) begin : g_bias
        assign mat[k][s] = 1'b1;
      end else begin : g_zero
        assign mat[k][s] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/tmul_dadda.sv
module tmul_dadda
  import tmul_pkg::*;
#(
  parameter int N    = 8,
  parameter int M    = 5,
  parameter int NK   = 11,
  parameter int MAXH = 9,
  parameter int CORR = 160
) (
  input  logic [NK-1:0][MAXH-1:0] mat,
  output logic [NK-1:0]           row_x,
  output logic [NK-1:0]           row_y
);

  localparam int W    = 2 * MAXH;
  localparam int NSTG = dadda_stages(MAXH);

  function automatic logic [2*NK-1:0] compress(input logic [NK-1:0][MAXH-1:0] m_in);
    logic [NK-1:0][W-1:0] cur;
    logic [NK-1:0][W-1:0] nxt;
    int cnt  [NK];
    int ncnt [NK];
    int p, d, ex;
    logic x, y, z;
    logic [2*NK-1:0] rows;
    for (int k = 0; k < NK; k++) begin
      cur[k] = '0;
      cur[k][MAXH-1:0] = m_in[k];
      cnt[k] = col_height(M + k, N, CORR);
    end
    for (int s = NSTG; s >= 1; s--) begin
      d = dadda_height(s);
      for (int k = 0; k < NK; k++) begin
        nxt[k]  = '0;
        ncnt[k] = 0;
      end
      for (int k = 0; k < NK; k++) begin
        p = 0;
        for (int it = 0; it < W; it++) begin
          ex = (cnt[k] - p) + ncnt[k] - d;
          if (ex >= 2 && cnt[k] - p >= 3) begin
            x = cur[k][p]; y = cur[k][p+1]; z = cur[k][p+2];
            p = p + 3;
            if (ncnt[k] < W) nxt[k][ncnt[k]] = x ^ y ^ z;
            ncnt[k]++;
            if (k + 1 < NK) begin
              if (ncnt[k+1] < W) nxt[k+1][ncnt[k+1]] = (x & y) | (z & (x ^ y));
              ncnt[k+1]++;
            end
          end else if (ex >= 1 && cnt[k] - p >= 2) begin
            x = cur[k][p]; y = cur[k][p+1];
            p = p + 2;
            if (ncnt[k] < W) nxt[k][ncnt[k]] = x ^ y;
            ncnt[k]++;
            if (k + 1 < NK) begin
              if (ncnt[k+1] < W) nxt[k+1][ncnt[k+1]] = x & y;
              ncnt[k+1]++;
            end
          end
        end
        for (int q = 0; q < W; q++) begin
          if (q >= p && q < cnt[k]) begin
            if (ncnt[k] < W) nxt[k][ncnt[k]] = cur[k][q];
            ncnt[k]++;
          end
        end
      end
      for (int k = 0; k < NK; k++) begin
        cur[k] = nxt[k];
        cnt[k] = ncnt[k];
      end
    end
    for (int k = 0; k < NK; k++) begin
      rows[k]      = cur[k][0];
      rows[NK + k] = cur[k][1];
    end
    return rows;
  endfunction

  logic [2*NK-1:0] rows;
  assign rows  = compress(mat);
  assign row_x = rows[NK-1:0];
  assign row_y = rows[2*NK-1:NK];

endmodule

// File: rtl/tmul_cpa.sv
module tmul_cpa #(
  parameter int NK    = 11,
  parameter int GUARD = 3
) (
  input  logic [NK-1:0]       row_x,
  input  logic [NK-1:0]       row_y,
  output logic [NK-GUARD-1:0] sum_hi,
  output logic                sum_cout
);

  localparam int HW = NK - GUARD;

  // Guard columns: ripple carry only, no sum bits formed.
  logic [GUARD:0] gc;
  assign gc[0] = 1'b0;
  for (genvar i = 0; i < GUARD; i++) begin : g_guard
    assign gc[i+1] = (row_x[i] & row_y[i]) | (gc[i] & (row_x[i] ^ row_y[i]));
  end

  logic [HW:0] total;
  assign total    = {1'b0, row_x[NK-1:GUARD]} + {1'b0, row_y[NK-1:GUARD]}
                  + {{HW{1'b0}}, gc[GUARD]};
  assign sum_hi   = total[HW-1:0];
  assign sum_cout = total[HW];

endmodule

// File: rtl/trunc_mul.sv
module trunc_mul
  import tmul_pkg::*;
#(
  parameter int N     = 8,
  parameter int GUARD = 3
) (
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [N-1:0] prod
);

  localparam int M    = N - GUARD;
  localparam int NK   = N + GUARD;
  localparam int MAXH = N + 1;
  localparam int CORR = corr_const(N, GUARD);

  logic [NK-1:0][MAXH-1:0] mat;
  logic [NK-1:0]           row_x;
  logic [NK-1:0]           row_y;
  logic                    sum_cout;

  tmul_ppgen #(.N(N), .M(M), .NK(NK), .MAXH(MAXH), .CORR(CORR)) u_pp (
    .op_a (op_a),
    .op_b (op_b),
    .mat  (mat)
  );

  tmul_dadda #(.N(N), .M(M), .NK(NK), .MAXH(MAXH), .CORR(CORR)) u_red (
    .mat   (mat),
    .row_x (row_x),
    .row_y (row_y)
  );

  tmul_cpa #(.NK(NK), .GUARD(GUARD)) u_add (
    .row_x    (row_x),
    .row_y    (row_y),
    .sum_hi   (prod),
    .sum_cout (sum_cout)
  );

  // Stateless stream: handshake passes straight through.
  assign res_valid = in_valid;
  assign in_ready  = res_ready;

endmodule

// File: rtl/trunc_mul_chk.sv
module trunc_mul_chk #(
  parameter int N     = 8,
  parameter int GUARD = 3
) (
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic         res_valid,
  input logic         res_ready,
  input logic [N-1:0] prod,
  input logic         sum_cout
);

  localparam int M = N - GUARD;

  logic [2*N-1:0] exact;
  logic [N:0]     hi_ext;
  logic [N:0]     prod_ext;
  assign exact    = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
  assign hi_ext   = {1'b0, exact[2*N-1:N]};
  assign prod_ext = {1'b0, prod};

  always_comb begin
    p_faithful_r2: assert (prod_ext == hi_ext ||
                           (prod_ext == hi_ext + 1'b1 && exact[N-1:0] != '0));
    p_no_overflow_r3: assert (!sum_cout && prod_ext >= hi_ext);
    p_zero_r4: assert (!(op_a == '0 || op_b == '0) || prod == '0);
    p_exact_r5: assert (exact[N-1:0] != '0 || prod_ext == hi_ext);
    p_max_r6: assert (!(&op_a && &op_b) || prod == {{(N-1){1'b1}}, 1'b0});
    p_stream_r7: assert (!(res_valid && res_ready) || (in_valid && in_ready));
    p_deleted_r8: assert ((exact >> M) != '0 || prod == '0);
  end

endmodule

bind trunc_mul trunc_mul_chk #(.N(N), .GUARD(GUARD)) u_chk (
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op_a      (op_a),
  .op_b      (op_b),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .prod      (prod),
  .sum_cout  (sum_cout)
);

// File: tb/sim_trunc_mul.sv
`timescale 1ns/1ps
module sim_trunc_mul;

  localparam int N     = 8;
  localparam int GUARD = 3;
  localparam int LIMIT = 190000;

  logic         clk = 1'b0;
  logic         in_valid = 1'b0;
  logic         res_ready = 1'b0;
  logic [N-1:0] op_a = '0;
  logic [N-1:0] op_b = '0;
  logic         in_ready;
  logic         res_valid;
  logic [N-1:0] prod;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  trunc_mul #(.N(N), .GUARD(GUARD)) u0 (
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op_a      (op_a),
    .op_b      (op_b),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .prod      (prod)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b);
    @(posedge clk);
    #2 {op_a, op_b} = {a, b};
    @(negedge clk);
  endtask

  function automatic bit faithful(input int a, input int b, input int r);
    int p, hi;
    p  = a * b;
    hi = p >> N;
    return (r == hi) || (r == hi + 1 && (p % (1 << N)) != 0);
  endfunction

  task automatic t_idle_r7();
    in_valid = 1'b0; res_ready = 1'b0;
    drive(8'd0, 8'd0);
    check(res_valid == 1'b0, "R7 idle res_valid", res_valid, 0);
    check(in_ready == 1'b0, "R7 idle in_ready", in_ready, 0);
    check($bits(prod) == N, "R1 result width", $bits(prod), N);
  endtask

  task automatic t_handshake_r7();
    logic [N-1:0] held;
    in_valid = 1'b1; res_ready = 1'b1;
    drive(8'd200, 8'd150);
    held = prod;
    check(res_valid && in_ready, "R7 transfer", {res_valid, in_ready}, 3);
    check(faithful(200, 150, prod), "R2 open", prod, (200 * 150) >> N);
    @(posedge clk); #2 res_ready = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b0, "R7 backpressure in_ready", in_ready, 0);
    check(res_valid == 1'b1, "R7 backpressure res_valid", res_valid, 1);
    check(prod == held, "R7 prod held under backpressure", prod, held);
    @(posedge clk); #2 in_valid = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R7 valid drop", res_valid, 0);
    check(prod == held, "R7 prod unaffected by valid", prod, held);
    in_valid = 1'b1; res_ready = 1'b1;
  endtask

  task automatic t_zero_r4();
    drive(8'd0, 8'd255);
    check(prod == 0, "R4 a zero", prod, 0);
    drive(8'd255, 8'd0);
    check(prod == 0, "R4 b zero", prod, 0);
    drive(8'd0, 8'd0);
    check(prod == 0, "R4 both zero", prod, 0);
  endtask

  task automatic t_max_r6();
    drive(8'd255, 8'd255);
    check(prod == 8'd254, "R6 max operands", prod, 254);
    check(prod >= ((255 * 255) >> N), "R3 max no wrap", prod, (255 * 255) >> N);
  endtask

  task automatic t_exact_r5();
    drive(8'd16, 8'd16);
    check(prod == 8'd1, "R5 16*16", prod, 1);
    drive(8'd128, 8'd2);
    check(prod == 8'd1, "R5 128*2", prod, 1);
    drive(8'd128, 8'd128);
    check(prod == 8'd64, "R5 128*128", prod, 64);
  endtask

  task automatic t_deleted_r8();
    drive(8'd1, 8'd31);
    check(prod == 0, "R8 1*31", prod, 0);
    drive(8'd3, 8'd10);
    check(prod == 0, "R8 3*10", prod, 0);
    drive(8'd1, 8'd1);
    check(prod == 0, "R8 1*1", prod, 0);
  endtask

  task automatic t_sweep_r2();
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        drive(a[N-1:0], b[N-1:0]);
        // R1 R2 R3: within one ulp and never below the exact upper half
        check(faithful(a, b, prod) && prod >= ((a * b) >> N),
              "R2 sweep", prod, (a * b) >> N);
      end
    end
  endtask

  initial begin
    t_idle_r7();
    t_handshake_r7();
    t_zero_r4();
    t_max_r6();
    t_exact_r5();
    t_deleted_r8();
    t_sweep_r2();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", LIMIT, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule